// File: doc/BRIEF.md
# Processor Status Flag Register

An 8-bit status register for a small accumulator-style processor core. It holds three groups of state. The first is the arithmetic flags: zero, digit carry and carry. The second is two reset-cause bits, time-out and power-down. The third is three data-memory bank select bits. In a given cycle the register can be updated from three directions at once. An instruction may name it as its destination and write data into it. The arithmetic datapath may report that the current operation produces flags. The power-management logic may pulse strobes for a watchdog clear, a sleep entry or a watchdog time-out. The block works out the next value from all three.

The block computes the flags itself from the operands it is given. It handles 8-bit add, subtract by two's-complement addition, a logic result, a rotate through carry in either direction, and a clear. Flag updates from the operation win over a data write to the flag bits. The reset-cause bits listen only to events and to power-on reset. The bank select bits go out on dedicated ports for the address generator. Power-up is the active-low reset.

Top module: `cpu_status_reg`

## Requirements
- R1: After reset, status bit 7 (indirect bank), bits 6:5 (direct bank) read 0, and bit 4 (time-out) and bit 3 (power-down) read 1.
- R2: With wr_en high and op_i = 0 (no flag operation, also for the spare code 7), bits 7:5 and 2:0 take wr_data in the next cycle.
- R3: A data write never changes bit 4 or bit 3. Without an event strobe, both hold their value.
- R4: op_i = 1 (add) computes opnd_a + opnd_b. Bit 0 (C) is the carry out of bit 7, bit 1 (DC) is the carry out of bit 3, and bit 2 (Z) is set when the 8-bit sum is zero.
- R5: op_i = 2 (subtract) computes opnd_a + ~opnd_b + 1. C and DC are 1 when no borrow occurs from bit 7 and from bit 3, and Z marks a zero result.
- R6: op_i = 3 (logic) sets Z when opnd_a (the logic result) is zero, and leaves DC and C unchanged.
- R7: op_i = 4 (rotate right) loads C from opnd_a bit 0, and op_i = 5 (rotate left) loads C from opnd_a bit 7. Z and DC are unchanged.
- R8: When any flag operation (op_i 1 to 6) coincides with a write, the write reaches only bits 7:5. Z, DC and C come from the operation or stay unchanged. A clear (op_i = 6) with write data 0 gives 000uu1uu.
- R9: A watchdog time-out clears bit 4. A sleep sets bit 4 and clears bit 3. A watchdog clear sets both. The time-out wins over sleep and clear on bit 4, and sleep wins over clear on bit 3.
- R10: dbank_o equals status bits 6:5 and ibank_o equals status bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Register is the destination of the current instruction |
| wr_data | input | 8 | Data written to the register |
| op_i | input | 3 | Flag operation code (0 none, 1 add, 2 sub, 3 logic, 4 rotate right, 5 rotate left, 6 clear) |
| opnd_a | input | 8 | First operand, logic result or rotate source |
| opnd_b | input | 8 | Second operand for add and subtract |
| ev_clrwdt | input | 1 | Watchdog clear strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_wdt_to | input | 1 | Watchdog time-out strobe |
| status_o | output | 8 | Current register value |
| dbank_o | output | 2 | Direct-addressing bank select |
| ibank_o | output | 1 | Indirect-addressing upper-range select |

## Verification
The assertions assume that op_i, the strobes and the write are single-cycle requests that are valid at the clock edge. They also assume that the reset-cause bits are meant to move only on strobes, so any cycle without a strobe must leave them still. The flag values after reset are left undefined by the requirements, so no check depends on them before the first write. The bench always loads known flags with a plain write before it tests an operation that leaves some flags unchanged. It drives every input at the falling edge and holds it for exactly one cycle.

// File: rtl/status_pkg.sv
package status_pkg;
    localparam int DATA_W = 8;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_LOGIC = 3'd3,
        OP_RR    = 3'd4,
        OP_RL    = 3'd5,
        OP_CLR   = 3'd6,
        OP_RSV   = 3'd7
    } flag_op_e;

    typedef struct packed {
        logic       ibank;
        logic [1:0] dbank;
        logic       tmo;
        logic       pwd;
        logic       z;
        logic       dc;
        logic       c;
    } status_t;

    typedef struct packed {
        logic z_en;
        logic dc_en;
        logic c_en;
        logic z;
        logic dc;
        logic c;
    } flag_upd_t;
endpackage

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import status_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  flag_op_e       op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output flag_upd_t      upd
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         cin;
    logic [W:0]   sum;
    logic [H:0]   low;

    always_comb begin
        cin   = (op == OP_SUB);
        b_eff = cin ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + (W+1)'(cin);
        low   = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + (H+1)'(cin);
        upd   = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                upd.z_en  = 1'b1;
                upd.dc_en = 1'b1;
                upd.c_en  = 1'b1;
                upd.z     = (sum[W-1:0] == '0);
                upd.dc    = low[H];
                upd.c     = sum[W];
            end
            OP_LOGIC: begin
                upd.z_en = 1'b1;
                upd.z    = (a == '0);
            end
            OP_RR: begin
                upd.c_en = 1'b1;
                upd.c    = a[0];
            end
            OP_RL: begin
                upd.c_en = 1'b1;
                upd.c    = a[W-1];
            end
            OP_CLR: begin
                upd.z_en = 1'b1;
                upd.z    = 1'b1;
            end
            default: upd = '0;
        endcase
    end
endmodule

// File: rtl/status_event_ctl.sv
module status_event_ctl (
    input  logic tmo_q,
    input  logic pwd_q,
    input  logic ev_clr,
    input  logic ev_slp,
    input  logic ev_to,
    output logic tmo_d,
    output logic pwd_d
);
    always_comb begin
        tmo_d = tmo_q;
        pwd_d = pwd_q;
        if (ev_to)
            tmo_d = 1'b0;
        else if (ev_slp || ev_clr)
            tmo_d = 1'b1;
        if (ev_slp)
            pwd_d = 1'b0;
        else if (ev_clr)
            pwd_d = 1'b1;
    end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
    import status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              ev_clrwdt,
    input  logic              ev_sleep,
    input  logic              ev_wdt_to,
    output logic [DATA_W-1:0] status_o,
    output logic [1:0]        dbank_o,
    output logic              ibank_o
);
    status_t   st_q, st_d;
    flag_upd_t upd;
    logic      tmo_d, pwd_d;
    logic      any_flag;

    status_flag_unit #(.W(DATA_W)) u_flags (
        .op  (flag_op_e'(op_i)),
        .a   (opnd_a),
        .b   (opnd_b),
        .upd (upd)
    );

    status_event_ctl u_events (
        .tmo_q  (st_q.tmo),
        .pwd_q  (st_q.pwd),
        .ev_clr (ev_clrwdt),
        .ev_slp (ev_sleep),
        .ev_to  (ev_wdt_to),
        .tmo_d  (tmo_d),
        .pwd_d  (pwd_d)
    );

    always_comb begin
        any_flag = upd.z_en | upd.dc_en | upd.c_en;
        st_d     = st_q;
        if (wr_en) begin
            st_d.ibank = wr_data[7];
            st_d.dbank = wr_data[6:5];
            if (!any_flag) begin
                st_d.z  = wr_data[2];
                st_d.dc = wr_data[1];
                st_d.c  = wr_data[0];
            end
        end
        if (upd.z_en)  st_d.z  = upd.z;
        if (upd.dc_en) st_d.dc = upd.dc;
        if (upd.c_en)  st_d.c  = upd.c;
        st_d.tmo = tmo_d;
        st_d.pwd = pwd_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ibank: 1'b0, dbank: 2'b00, tmo: 1'b1, pwd: 1'b1,
                       z: 1'b0, dc: 1'b0, c: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q;
    assign dbank_o  = st_q.dbank;
    assign ibank_o  = st_q.ibank;
endmodule

// File: rtl/status_reg_chk.sv
module status_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [2:0] op_i,
    input logic [7:0] opnd_a,
    input logic       ev_clrwdt,
    input logic       ev_sleep,
    input logic       ev_wdt_to,
    input logic [7:0] status_o
);
    // R3
    tocause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_clrwdt || ev_sleep || ev_wdt_to) |=> $stable(status_o[4:3]));

    // R9
    timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_to |=> status_o[4] == 1'b0);

    // R9
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && !ev_wdt_to) |=> status_o[4:3] == 2'b10);

    // R2
    plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op_i == 3'd0 || op_i == 3'd7)) |=>
        (status_o[7:5] == $past(wr_data[7:5]) && status_o[2:0] == $past(wr_data[2:0])));

    // R7
    rotr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> status_o[0] == $past(opnd_a[0]));

    // R6
    logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> $stable(status_o[1:0]));
endmodule

bind cpu_status_reg status_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .op_i      (op_i),
    .opnd_a    (opnd_a),
    .ev_clrwdt (ev_clrwdt),
    .ev_sleep  (ev_sleep),
    .ev_wdt_to (ev_wdt_to),
    .status_o  (status_o)
);

// File: tb/cpu_status_reg_tb.sv
module cpu_status_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] op_i = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       ev_clrwdt = 1'b0;
    logic       ev_sleep = 1'b0;
    logic       ev_wdt_to = 1'b0;
    logic [7:0] status_o;
    logic [1:0] dbank_o;
    logic       ibank_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    cpu_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_i(op_i), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .ev_clrwdt(ev_clrwdt), .ev_sleep(ev_sleep), .ev_wdt_to(ev_wdt_to),
        .status_o(status_o), .dbank_o(dbank_o), .ibank_o(ibank_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus: drive after a falling edge, result visible at the next one
    task automatic cyc(input logic we, input logic [7:0] wd, input logic [2:0] op,
                       input logic [7:0] a, input logic [7:0] b,
                       input logic clr, input logic slp, input logic to);
        wr_en = we; wr_data = wd; op_i = op; opnd_a = a; opnd_b = b;
        ev_clrwdt = clr; ev_sleep = slp; ev_wdt_to = to;
        @(negedge clk);
        wr_en = 1'b0; op_i = 3'd0; ev_clrwdt = 1'b0; ev_sleep = 1'b0; ev_wdt_to = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        cyc(1'b1, d, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 reset upper bits", {3'b000, status_o[7:3]}, 8'h03);
    endtask

    task automatic t_write;
        wr(8'hE7);
        chk("R2 write E7", status_o & 8'hE7, 8'hE7);
        chk("R3 write keeps TO/PD", {6'd0, status_o[4:3]}, 8'h03);
        wr(8'h00);
        chk("R2 R3 write 00", status_o, 8'h18);
        cyc(1'b1, 8'h05, 3'd7, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R2 spare op code writes", status_o, 8'h1D);
    endtask

    task automatic t_add;
        cyc(1'b0, 8'h00, 3'd1, 8'h0F, 8'h01, 1'b0, 1'b0, 1'b0);
        chk("R4 add 0F+01", {5'd0, status_o[2:0]}, 8'h02);
        cyc(1'b0, 8'h00, 3'd1, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);
        chk("R4 add FF+01", {5'd0, status_o[2:0]}, 8'h07);
        cyc(1'b0, 8'h00, 3'd1, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0);
        chk("R4 add 80+80", {5'd0, status_o[2:0]}, 8'h05);
    endtask

    task automatic t_sub;
        cyc(1'b0, 8'h00, 3'd2, 8'h05, 8'h03, 1'b0, 1'b0, 1'b0);
        chk("R5 sub 5-3", {5'd0, status_o[2:0]}, 8'h03);
        cyc(1'b0, 8'h00, 3'd2, 8'h03, 8'h05, 1'b0, 1'b0, 1'b0);
        chk("R5 sub 3-5", {5'd0, status_o[2:0]}, 8'h00);
        cyc(1'b0, 8'h00, 3'd2, 8'h05, 8'h05, 1'b0, 1'b0, 1'b0);
        chk("R5 sub 5-5", {5'd0, status_o[2:0]}, 8'h07);
    endtask

    task automatic t_logic;
        wr(8'h03);
        cyc(1'b0, 8'h00, 3'd3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R6 logic zero", {5'd0, status_o[2:0]}, 8'h07);
        cyc(1'b0, 8'h00, 3'd3, 8'h40, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R6 logic nonzero", {5'd0, status_o[2:0]}, 8'h03);
    endtask

    task automatic t_rotate;
        wr(8'h04);
        cyc(1'b0, 8'h00, 3'd4, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R7 rotr from bit0", {5'd0, status_o[2:0]}, 8'h05);
        cyc(1'b0, 8'h00, 3'd5, 8'h7F, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R7 rotl from bit7 low", {5'd0, status_o[2:0]}, 8'h04);
        cyc(1'b0, 8'h00, 3'd5, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R7 rotl from bit7 high", {5'd0, status_o[2:0]}, 8'h05);
    endtask

    task automatic t_flag_write;
        wr(8'hE3);
        cyc(1'b1, 8'h00, 3'd6, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R8 clear to 000uu1uu", status_o, 8'h1F);
        cyc(1'b1, 8'hE0, 3'd1, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0);
        chk("R8 add with write", status_o, 8'hF8);
        wr(8'h03);
        cyc(1'b1, 8'h00, 3'd3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R8 logic write masks DC/C", status_o, 8'h1F);
    endtask

    task automatic t_events;
        cyc(1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R9 timeout", {6'd0, status_o[4:3]}, 8'h01);
        cyc(1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        chk("R9 sleep", {6'd0, status_o[4:3]}, 8'h02);
        cyc(1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
        chk("R9 clrwdt", {6'd0, status_o[4:3]}, 8'h03);
        cyc(1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
        chk("R9 timeout+sleep", {6'd0, status_o[4:3]}, 8'h00);
        cyc(1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
        chk("R9 timeout+clrwdt", {6'd0, status_o[4:3]}, 8'h01);
        cyc(1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0);
        chk("R9 sleep+clrwdt", {6'd0, status_o[4:3]}, 8'h02);
        cyc(1'b1, 8'h18, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R3 write cannot set PD", {6'd0, status_o[4:3]}, 8'h02);
        cyc(1'b1, 8'h18, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R3 event wins over write", {6'd0, status_o[4:3]}, 8'h00);
    endtask

    task automatic t_bank;
        wr(8'hA0);
        chk("R10 direct bank 01", {6'd0, dbank_o}, 8'h01);
        chk("R10 indirect 1", {7'd0, ibank_o}, 8'h01);
        wr(8'h40);
        chk("R10 direct bank 10", {6'd0, dbank_o}, 8'h02);
        chk("R10 indirect 0", {7'd0, ibank_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_flag_write();
        t_events();
        t_bank();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule